// File: doc/BRIEF.md
# Flash Programming Command Sequencer

This block sits between a host word channel and a parallel NOR flash with a 16-bit data bus. The host sends 32-bit command words whose values are ASCII mnemonics. Two of these words load a range: a start block number and an end word address. Three others launch an operation over that range: unlocking the blocks, erasing them, or programming them word by word from a first-word-fall-through buffer. The block turns each operation into a series of two-write flash bus sequences. It paces the write-enable strobe and waits on the flash ready/busy pin after every erase and every programmed word.

An operation that finishes raises a one-cycle completion pulse. If the flash stays busy for too long, the operation is abandoned and a sticky timeout flag is set. A command word that arrives while an operation runs is dropped and reported with a one-cycle pulse. The channel never back-pressures. The host is expected to send the range words first, then unlock, then erase, then program.

Top module: `flash_cmd_seq`

## Requirements
- R1: While idle, a command word with bits 31:16 equal to 0x5341 stores bits 15:0 as the start block number. The first word address of the range is that number shifted left by BLK_SHIFT.
- R2: While idle, the exact word 0x45726173 starts an erase. Any other word with bits 31:24 equal to 0x45 stores bits 23:0 as the inclusive end word address.
- R3: Word 0x556E6C6B performs two flash writes per block, data 0x0060 and then 0x00D0, at each block's first word address. It runs from the start block up to and including the block that holds the end address, then pulses done for one cycle.
- R4: Erase (0x45726173) performs writes of 0x0020 and then 0x00D0 per block over the same range. After each block it waits for the ready input to be high before issuing the next write, and it pulses done after the last block.
- R5: Word 0x50726F67 programs every word address from the range start through the end address in increasing order. Each address gets a write of 0x0040 and then a write of one word popped from the buffer, then a wait for ready. Done pulses after the end address.
- R6: While the buffer reports empty, programming stalls with no pop and no flash write. It resumes when data appears. Every programmed value is one that was popped.
- R7: Chip enable goes low one cycle before write enable falls and stays low for one cycle after it rises. Write enable stays low for exactly WE_LEN cycles. Address and data hold steady while chip enable is low. Output enable stays high.
- R8: If ready stays low for TMO_CYC cycles during a wait, the operation stops without a done pulse and a sticky timeout flag sets. Starting the next operation clears the flag.
- R9: A command word presented while busy produces a one-cycle reject pulse one cycle later and changes neither the stored range nor the running operation.
- R10: After reset, chip enable, write enable and output enable are high, and busy, done and both error outputs are low.
- R11: While idle, a command word matching none of the patterns above causes no flash activity and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_data | input | 32 | Host command word |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Always high; every word is taken |
| fifo_data | input | DATA_W | Buffer head word |
| fifo_empty | input | 1 | Buffer holds no word |
| fifo_rd | output | 1 | Pop the buffer head |
| fl_addr | output | ADDR_W | Flash word address |
| fl_dq | output | DATA_W | Flash write data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_rdy | input | 1 | Flash ready (high) / busy (low) |
| done | output | 1 | One-cycle completion pulse |
| err_tmo | output | 1 | Sticky ready-wait timeout |
| err_cmd | output | 1 | One-cycle reject pulse for a command while busy |
| busy | output | 1 | Operation in progress |

## Verification
A wrong range register or a wrong address step shows up at the port on the first flash write of the next operation. That write lands at a wrong address, or it carries a wrong command code. A faulty sequencer state shows as a missing or extra write in the logged bus trace, or as a write issued while ready is low. A sequencer stuck in its wait shows as a missing done pulse within a few hundred cycles. The strobe generator is checked on every write against its fixed pulse width and its chip-enable margins, so a timing fault appears on the very first bus cycle.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    // Host command word patterns
    localparam logic [15:0] HC_START_TAG = 16'h5341;
    localparam logic [7:0]  HC_END_TAG   = 8'h45;
    localparam logic [31:0] HC_UNLOCK    = 32'h556E6C6B;
    localparam logic [31:0] HC_ERASE     = 32'h45726173;
    localparam logic [31:0] HC_PROG      = 32'h50726F67;

    // Flash bus command codes
    localparam logic [7:0] FC_UNLK = 8'h60;
    localparam logic [7:0] FC_ERS  = 8'h20;
    localparam logic [7:0] FC_PGM  = 8'h40;
    localparam logic [7:0] FC_CONF = 8'hD0;

    typedef enum logic [2:0] {
        HK_NONE, HK_START, HK_END, HK_UNLOCK, HK_ERASE, HK_PROG
    } host_kind_e;

    typedef enum logic [1:0] {OP_UNLOCK, OP_ERASE, OP_PROG} op_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_FETCH, SQ_W1, SQ_W2, SQ_POLL, SQ_ADV
    } seq_st_e;

    typedef enum logic [1:0] {BC_IDLE, BC_SETUP, BC_STROBE, BC_HOLD} bc_st_e;

    typedef struct packed {
        host_kind_e  kind;
        logic [23:0] arg;
    } host_cmd_t;

    // Exact words are tested before the tag patterns: erase shares the end tag byte.
    function automatic host_cmd_t decode_host(input logic [31:0] w);
        host_cmd_t r;
        r.arg  = w[23:0];
        if (w == HC_UNLOCK)                 r.kind = HK_UNLOCK;
        else if (w == HC_ERASE)             r.kind = HK_ERASE;
        else if (w == HC_PROG)              r.kind = HK_PROG;
        else if (w[31:16] == HC_START_TAG)  r.kind = HK_START;
        else if (w[31:24] == HC_END_TAG)    r.kind = HK_END;
        else                                r.kind = HK_NONE;
        return r;
    endfunction

    function automatic logic [7:0] lead_code(input op_e op);
        case (op)
            OP_UNLOCK: return FC_UNLK;
            OP_ERASE:  return FC_ERS;
            default:   return FC_PGM;
        endcase
    endfunction

endpackage

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode
    import flash_seq_pkg::*;
(
    input  logic [31:0] word,
    output host_cmd_t   cmd
);
    always_comb cmd = decode_host(word);
endmodule

// File: rtl/seq_bus_cycle.sv
module seq_bus_cycle
    import flash_seq_pkg::*;
#(
    parameter int AW     = 24,
    parameter int DW     = 16,
    parameter int WE_LEN = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          idle,
    output logic          fin,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data,
    output logic          ce_n,
    output logic          we_n
);
    localparam int CW = $clog2(WE_LEN + 1);

    bc_st_e        st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= BC_IDLE;
            cnt      <= '0;
            bus_addr <= '0;
            bus_data <= '0;
        end else begin
            case (st)
                BC_IDLE: if (go) begin
                    st       <= BC_SETUP;
                    bus_addr <= addr;
                    bus_data <= data;
                end
                BC_SETUP: begin
                    st  <= BC_STROBE;
                    cnt <= '0;
                end
                BC_STROBE: begin
                    if (cnt == CW'(WE_LEN - 1)) st <= BC_HOLD;
                    else                        cnt <= cnt + 1'b1;
                end
                default: st <= BC_IDLE;
            endcase
        end
    end

    assign idle = (st == BC_IDLE);
    assign fin  = (st == BC_HOLD);
    assign ce_n = (st == BC_IDLE);
    assign we_n = (st != BC_STROBE);
endmodule

// File: rtl/seq_poll_timer.sv
module seq_poll_timer #(
    parameter int TMO_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rdy,
    output logic ok,
    output logic expired
);
    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)  cnt <= '0;
        else if (!rdy)   cnt <= cnt + 1'b1;
    end

    assign ok      = en && rdy;
    assign expired = en && !rdy && (cnt == CW'(TMO_CYC - 1));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int BLK_SHIFT = 16,
    parameter int WE_LEN    = 4,
    parameter int TMO_CYC   = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       cmd_data,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_rd,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n,
    input  logic              fl_rdy,
    output logic              done,
    output logic              err_tmo,
    output logic              err_cmd,
    output logic              busy
);
    localparam int          BN_W      = ADDR_W - BLK_SHIFT;
    localparam [ADDR_W-1:0] BLK_WORDS = ADDR_W'(1) << BLK_SHIFT;

    seq_st_e           st;
    op_e               op;
    host_cmd_t         hc;
    logic [15:0]       start_blk;
    logic [ADDR_W-1:0] end_addr, cur_addr, base_addr;
    logic [DATA_W-1:0] wbuf, bus_wdata;
    logic              bus_go, bus_idle, bus_fin, poll_ok, poll_exp;
    logic              last_blk, last_wd, is_last;

    seq_cmd_decode u_dec (.word(cmd_data), .cmd(hc));

    assign base_addr = ADDR_W'(start_blk) << BLK_SHIFT;
    assign last_blk  = cur_addr[ADDR_W-1 -: BN_W] >= end_addr[ADDR_W-1 -: BN_W];
    assign last_wd   = cur_addr >= end_addr;
    assign is_last   = (op == OP_PROG) ? last_wd : last_blk;

    assign bus_go    = (st == SQ_W1 || st == SQ_W2) && bus_idle;
    assign bus_wdata = (st == SQ_W1)   ? DATA_W'(lead_code(op)) :
                       (op == OP_PROG) ? wbuf : DATA_W'(FC_CONF);

    seq_bus_cycle #(.AW(ADDR_W), .DW(DATA_W), .WE_LEN(WE_LEN)) u_bus (
        .clk(clk), .rst(rst), .go(bus_go), .addr(cur_addr), .data(bus_wdata),
        .idle(bus_idle), .fin(bus_fin), .bus_addr(fl_addr), .bus_data(fl_dq),
        .ce_n(fl_ce_n), .we_n(fl_we_n)
    );

    seq_poll_timer #(.TMO_CYC(TMO_CYC)) u_poll (
        .clk(clk), .rst(rst), .en(st == SQ_POLL), .rdy(fl_rdy),
        .ok(poll_ok), .expired(poll_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            op        <= OP_UNLOCK;
            start_blk <= '0;
            end_addr  <= '0;
            cur_addr  <= '0;
            wbuf      <= '0;
            done      <= 1'b0;
            err_tmo   <= 1'b0;
            err_cmd   <= 1'b0;
        end else begin
            done    <= 1'b0;
            err_cmd <= cmd_valid && (st != SQ_IDLE);
            case (st)
                SQ_IDLE: if (cmd_valid) begin
                    case (hc.kind)
                        HK_START: start_blk <= hc.arg[15:0];
                        HK_END:   end_addr  <= ADDR_W'(hc.arg);
                        HK_UNLOCK, HK_ERASE, HK_PROG: begin
                            op       <= (hc.kind == HK_UNLOCK) ? OP_UNLOCK :
                                        (hc.kind == HK_ERASE)  ? OP_ERASE : OP_PROG;
                            cur_addr <= base_addr;
                            err_tmo  <= 1'b0;
                            st       <= (hc.kind == HK_PROG) ? SQ_FETCH : SQ_W1;
                        end
                        default: ;
                    endcase
                end
                SQ_FETCH: if (!fifo_empty) begin
                    wbuf <= fifo_data;
                    st   <= SQ_W1;
                end
                SQ_W1: if (bus_fin) st <= SQ_W2;
                SQ_W2: if (bus_fin) st <= (op == OP_UNLOCK) ? SQ_ADV : SQ_POLL;
                SQ_POLL: begin
                    if (poll_ok) begin
                        st <= SQ_ADV;
                    end else if (poll_exp) begin
                        err_tmo <= 1'b1;
                        st      <= SQ_IDLE;
                    end
                end
                SQ_ADV: begin
                    if (is_last) begin
                        done <= 1'b1;
                        st   <= SQ_IDLE;
                    end else if (op == OP_PROG) begin
                        cur_addr <= cur_addr + 1'b1;
                        st       <= SQ_FETCH;
                    end else begin
                        cur_addr <= cur_addr + BLK_WORDS;
                        st       <= SQ_W1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign fifo_rd   = (st == SQ_FETCH) && !fifo_empty;
    assign busy      = (st != SQ_IDLE);
    assign cmd_ready = 1'b1;
    assign fl_oe_n   = 1'b1;
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
    parameter int AW     = 24,
    parameter int DW     = 16,
    parameter int WE_LEN = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          fifo_rd,
    input logic          fifo_empty,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_dq,
    input logic          fl_ce_n,
    input logic          fl_we_n,
    input logic          done,
    input logic          err_tmo,
    input logic          err_cmd,
    input logic          busy
);
    localparam int LW = $clog2(WE_LEN + 2) + 1;
    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || fl_we_n) low_run <= '0;
        else                low_run <= low_run + 1'b1;
    end

    // R7
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> !fl_ce_n);

    // R7
    bus_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dq)));

    // R7
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> (low_run == LW'(WE_LEN)));

    // R6
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);

    // R8
    done_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !err_tmo);

    // R9
    reject_cause_chk: assert property (@(posedge clk) disable iff (rst)
        err_cmd |-> $past(cmd_valid && busy));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> fl_ce_n);
endmodule

bind flash_cmd_seq seq_chk #(.AW(ADDR_W), .DW(DATA_W), .WE_LEN(WE_LEN)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .fifo_rd(fifo_rd),
    .fifo_empty(fifo_empty), .fl_addr(fl_addr), .fl_dq(fl_dq),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .done(done), .err_tmo(err_tmo),
    .err_cmd(err_cmd), .busy(busy)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
    localparam int CLK_PER = 10;
    localparam int AW = 16, DW = 16, BS = 3, WL = 3, TMO = 40, FBUSY = 5;

    logic          clk = 1'b0, rst = 1'b1;
    logic [31:0]   cmd_data = '0;
    logic          cmd_valid = 1'b0, cmd_ready, fifo_rd, fifo_empty;
    logic [DW-1:0] fifo_data;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq;
    logic          fl_ce_n, fl_we_n, fl_oe_n, done, err_tmo, err_cmd, busy;
    logic          fl_rdy = 1'b1;

    always #(CLK_PER/2) clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .BLK_SHIFT(BS), .WE_LEN(WL), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst(rst), .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
        .fl_addr(fl_addr), .fl_dq(fl_dq), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
        .fl_oe_n(fl_oe_n), .fl_rdy(fl_rdy), .done(done), .err_tmo(err_tmo),
        .err_cmd(err_cmd), .busy(busy)
    );

    // Buffer model (first word falls through)
    logic [DW-1:0] fmem [0:15];
    int wp = 0, rp = 0;
    assign fifo_empty = (wp == rp);
    assign fifo_data  = fmem[rp % 16];
    always @(posedge clk) if (fifo_rd) rp <= rp + 1;

    // Flash model and bus monitors, sampled on the falling edge
    logic [AW-1:0] log_a [0:63];
    logic [DW-1:0] log_d [0:63];
    int nlog = 0, bcnt = 0, viol = 0, strobe_bad = 0, oe_bad = 0, lowrun = 0;
    int done_cnt = 0, rej_cnt = 0;
    bit pend = 0, stuck = 0, we_prev = 1, ce_prev = 1;
    logic [7:0] pcode = '0;

    always @(negedge clk) begin
        if (rst) begin
            we_prev = 1; ce_prev = 1; pend = 0; fl_rdy = 1;
        end else begin
            if (!fl_oe_n) oe_bad++;
            if (done) done_cnt++;
            if (err_cmd) rej_cnt++;
            if (we_prev && !fl_we_n) begin
                if (ce_prev) strobe_bad++;
                if (!fl_rdy) viol++;
            end
            if (!fl_we_n) lowrun++;
            if (!ce_prev && fl_ce_n && !we_prev) strobe_bad++;
            if (!we_prev && fl_we_n) begin
                if (lowrun != WL) strobe_bad++;
                lowrun = 0;
                if (nlog < 64) begin log_a[nlog] = fl_addr; log_d[nlog] = fl_dq; end
                nlog++;
                if (pend) begin
                    pend = 0;
                    if (pcode == 8'h40 || (pcode == 8'h20 && fl_dq == 16'h00D0)) begin
                        fl_rdy = 0; bcnt = FBUSY;
                    end
                end else begin
                    pend = 1; pcode = fl_dq[7:0];
                end
            end else if (!fl_rdy && !stuck) begin
                if (bcnt <= 1) fl_rdy = 1; else bcnt--;
            end
            we_prev = fl_we_n;
            ce_prev = fl_ce_n;
        end
    end

    int tests = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk); cmd_data = w; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic push(input logic [DW-1:0] v);
        @(negedge clk); fmem[wp % 16] = v; wp++;
    endtask

    task automatic wait_done(input int base, input string tag);
        int n = 0;
        while (done_cnt == base && n < 2000) begin @(negedge clk); n++; end
        chk(done_cnt == base + 1, tag, done_cnt - base, 1);
    endtask

    task automatic chk_wr(input int idx, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        chk(log_a[idx] == a, {tag, " addr"}, log_a[idx], a);
        chk(log_d[idx] == d, {tag, " data"}, log_d[idx], d);
    endtask

    task automatic t_reset();
        chk(fl_ce_n && fl_we_n && fl_oe_n, "R10 strobes high", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
        chk(!busy && !done && !err_tmo && !err_cmd, "R10 status low",
            {busy, done, err_tmo, err_cmd}, 0);
    endtask

    task automatic t_unlock();
        int b = nlog, d0 = done_cnt;
        send(32'h53410001);            // R1: start block 1 -> word 8
        send(32'h45000015);            // R2: end word 21 -> block 2
        send(32'h556E6C6B);
        wait_done(d0, "R3 unlock done");
        chk(nlog - b == 4, "R3 unlock write count", nlog - b, 4);
        chk_wr(b,   16'd8,  16'h0060, "R1 R3 blk1 lead");
        chk_wr(b+1, 16'd8,  16'h00D0, "R3 blk1 confirm");
        chk_wr(b+2, 16'd16, 16'h0060, "R2 R3 blk2 lead");
        chk_wr(b+3, 16'd16, 16'h00D0, "R3 blk2 confirm");
    endtask

    task automatic t_erase();
        int b = nlog, d0 = done_cnt;
        send(32'h45726173);            // R2: exact erase word, not an end address
        wait_done(d0, "R4 erase done");
        chk(nlog - b == 4, "R2 R4 erase write count", nlog - b, 4);
        chk_wr(b,   16'd8,  16'h0020, "R4 blk1 lead");
        chk_wr(b+1, 16'd8,  16'h00D0, "R4 blk1 confirm");
        chk_wr(b+2, 16'd16, 16'h0020, "R4 blk2 lead");
        chk_wr(b+3, 16'd16, 16'h00D0, "R4 blk2 confirm");
        chk(viol == 0, "R4 no write while busy", viol, 0);
    endtask

    task automatic t_program();
        int b = nlog, d0 = done_cnt, r0 = rej_cnt;
        send(32'h4500000B);            // end word 11, start still word 8
        send(32'h50726F67);
        push(16'hA1B2); push(16'hC3D4);
        repeat (150) @(negedge clk);
        chk(nlog - b == 4, "R6 stall write count", nlog - b, 4);
        chk(busy && done_cnt == d0, "R6 stalled busy", {busy, done_cnt - d0}, 2'b10);
        send(32'h53410005);            // R9: rejected while busy
        repeat (2) @(negedge clk);
        chk(rej_cnt == r0 + 1, "R9 reject pulse", rej_cnt - r0, 1);
        push(16'h1357); push(16'h2468);
        wait_done(d0, "R5 program done");
        chk(nlog - b == 8, "R5 program write count", nlog - b, 8);
        chk_wr(b,   16'd8,  16'h0040, "R5 w8 lead");
        chk_wr(b+1, 16'd8,  16'hA1B2, "R5 w8 data");
        chk_wr(b+3, 16'd9,  16'hC3D4, "R5 w9 data");
        chk_wr(b+5, 16'd10, 16'h1357, "R6 w10 data after stall");
        chk_wr(b+6, 16'd11, 16'h0040, "R5 w11 lead");
        chk_wr(b+7, 16'd11, 16'h2468, "R5 w11 data");
        chk(rp == wp, "R6 pops equal pushes", rp, wp);
        chk(viol == 0, "R5 no write while busy", viol, 0);
    endtask

    task automatic t_retained();
        int b = nlog, d0 = done_cnt;
        send(32'h556E6C6B);            // R9: range must be unchanged by the rejected word
        wait_done(d0, "R9 unlock after reject");
        chk(nlog - b == 2, "R9 range kept count", nlog - b, 2);
        chk_wr(b, 16'd8, 16'h0060, "R9 start kept");
    endtask

    task automatic t_unknown();
        int b = nlog, r0 = rej_cnt;
        send(32'h12345678);
        repeat (10) @(negedge clk);
        chk(nlog == b && !busy, "R11 unknown ignored", {nlog - b, busy}, 0);
        chk(rej_cnt == r0, "R11 no reject", rej_cnt - r0, 0);
    endtask

    task automatic t_timeout();
        int d0 = done_cnt;
        send(32'h53410000);
        send(32'h45000002);
        stuck = 1;
        send(32'h45726173);
        repeat (100) @(negedge clk);
        chk(err_tmo == 1'b1, "R8 timeout flag", err_tmo, 1);
        chk(!busy && done_cnt == d0, "R8 abort no done", {busy, done_cnt - d0}, 0);
        stuck = 0;
        repeat (3) @(negedge clk);
        send(32'h556E6C6B);
        chk(err_tmo == 1'b0, "R8 flag cleared on start", err_tmo, 0);
        wait_done(d0, "R8 next op done");
    endtask

    task automatic t_strobe();
        chk(strobe_bad == 0, "R7 strobe timing", strobe_bad, 0);
        chk(oe_bad == 0, "R7 output enable high", oe_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unlock();
        t_erase();
        t_program();
        t_retained();
        t_unknown();
        t_timeout();
        t_strobe();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule